// File: doc/BRIEF.md
# Current-Form Discrete Extended State Observer

This block estimates three states of a second-order plant from one measured output: the output itself, its rate, and a lumped "total disturbance" that collects unmodelled dynamics and external loads. It is a third-order linear observer in fixed point. Each pulse on `sample_i` starts one update. The update reads the measurement `y_i` and the control value `u_i` applied over the coming interval. It first corrects the held prediction using the estimation error of this same sample. It then pushes the corrected vector through the discretized integrator chain to form the prediction for the next sample. The corrected vector is what the block presents on its outputs. Using the correction within the same sample, rather than only in the next prediction, removes one sample of delay from the estimate that a controller consumes.

All gains and model constants are parameters in signed fixed point with `CF` fraction bits, computed off-line. The defaults use time-scaled states. The rate state is stored multiplied by the sample period Ts, and the disturbance state by Ts squared. With that scaling the transition-matrix entries become 1, 1/2 and 1, and all coefficients fit one format. The default gains place all three discrete poles at exp(-600 rad/s x 81.92 us): an observer bandwidth five times a 120 rad/s loop, sampled every 4096 cycles of a 20 ns clock.

Every adder and multiplier is followed by a register. An update therefore takes six clock edges, far below the sample period. A strobe that arrives while an update is in flight is ignored.

Top module: `eso_current_observer`

## Requirements
- R1: After reset, `valid_o` is 0 and the three estimate outputs and the internal prediction are all 0.
- R2: On an accepted strobe with held prediction (p1,p2,p3), the error is e = sat(y - p1). The outputs become est_pos = sat(p1 + mul(e,L1)), est_rate = sat(p2 + mul(e,L2)) and est_dist = sat(p3 + mul(e,L3)).
- R3: From the corrected vector (c1,c2,c3) the next prediction is formed as follows. p1' = sat(sat(c1 + mul(c2,PH12)) + sat(mul(c3,PH13) + mul(u,G1))). p2' = sat(sat(c2 + mul(c3,PH23)) + mul(u,G2)). p3' = c3.
- R4: mul(a,c) = sat(floor(a*c / 2^CF)). sat() clamps to the signed DW-bit range [-2^(DW-1), 2^(DW-1)-1]. Every sum saturates to that range.
- R5: `valid_o` is a one-cycle pulse. It is high in the sixth clock cycle after the edge that accepts a strobe. The outputs take their new values in that same cycle.
- R6: The outputs and the prediction do not change except in a cycle where `valid_o` is high. `valid_o` is never high without an accepted strobe.
- R7: A strobe that is sampled in the five edges following an accepted strobe is ignored. A strobe sampled in the cycle where `valid_o` is high is accepted.
- R8: `y_i` and `u_i` are taken only at the accepting edge. Changes to them afterwards do not affect that update.
- R9: Large inputs or gains drive the estimates onto the positive and negative rails (2^(DW-1)-1 and -2^(DW-1)). They never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sample strobe, starts one update |
| y_i | input | DW | Measured plant output, signed |
| u_i | input | DW | Control value for this sample, signed, scaled by b0 Ts^2 through G1/G2 |
| valid_o | output | 1 | One-cycle pulse when new estimates are presented |
| est_pos_o | output | DW | Corrected output estimate |
| est_rate_o | output | DW | Corrected rate estimate (time-scaled) |
| est_dist_o | output | DW | Corrected total-disturbance estimate (time-scaled) |

## Verification
The hardest situation to reach from the ports is saturation deep in the prediction path. There, a product and a sum clip in the same update, and the clipped value then feeds the next correction. Small, realistic inputs never get there. The bench therefore runs a second instance with gains and input coefficients of several units. Its first sample drives both inputs to the positive rail and the next ones to the negative rail, so every clamp in both directions is exercised while a bit-exact arithmetic model follows. The strobe-while-busy case is reached by pulsing the strobe two cycles into an update and again in the exact cycle the result appears.

// File: rtl/eso_pkg.sv
package eso_pkg;
    // number of observer states: position, rate, disturbance
    localparam int NSTATE = 3;
    // registered stages between the accepting edge and the state write
    localparam int ESO_STAGES = 5;
endpackage

// File: rtl/eso_cmul.sv
// Registered coefficient multiply: p = sat(floor(a*COEF / 2^CF))
module eso_cmul #(
    parameter int DW   = 24,
    parameter int CW   = 24,
    parameter int CF   = 20,
    parameter int COEF = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] a_i,
    output logic signed [DW-1:0] p_o
);
    localparam int PW = DW + CW;
    localparam logic signed [CW-1:0] COEF_C = CW'(COEF);
    localparam logic signed [DW-1:0] MAXV   = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV   = {1'b1, {(DW-1){1'b0}}};

    logic signed [PW-1:0] prod_w;
    logic signed [PW-1:0] shf_w;
    logic signed [DW-1:0] p_d, p_q;

    always_comb begin
        prod_w = PW'(a_i) * PW'(COEF_C);
        shf_w  = prod_w >>> CF;
        if ((&shf_w[PW-1:DW-1]) || !(|shf_w[PW-1:DW-1])) begin
            p_d = shf_w[DW-1:0];
        end else begin
            p_d = shf_w[PW-1] ? MINV : MAXV;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign p_o = p_q;

    // R4: a zero operand yields a zero product one cycle later
    p_zero_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_i == '0) |=> (p_o == '0));
    // R4: no wrap: positive operand and non-negative coefficient never give a negative product
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (COEF >= 0 && !a_i[DW-1]) |=> !p_o[DW-1]);
endmodule

// File: rtl/eso_sadd.sv
// Registered saturating add (SUB=0) or subtract (SUB=1)
module eso_sadd #(
    parameter int DW  = 24,
    parameter int SUB = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] b_i,
    output logic signed [DW-1:0] s_o
);
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0]          sum_w;
    logic signed [DW-1:0] s_d, s_q;

    always_comb begin
        if (SUB != 0) sum_w = {a_i[DW-1], a_i} - {b_i[DW-1], b_i};
        else          sum_w = {a_i[DW-1], a_i} + {b_i[DW-1], b_i};
        if (sum_w[DW] != sum_w[DW-1]) s_d = sum_w[DW] ? MINV : MAXV;
        else                          s_d = sum_w[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign s_o = s_q;

    // R4/R9: non-negative operands never produce a negative result (no wrap)
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((SUB == 0 && !a_i[DW-1] && !b_i[DW-1]) ||
         (SUB != 0 && !a_i[DW-1] &&  b_i[DW-1])) |=> !s_o[DW-1]);
    // R9: negative operands never produce a non-negative result
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((SUB == 0 && a_i[DW-1] && b_i[DW-1]) ||
         (SUB != 0 && a_i[DW-1] && !b_i[DW-1])) |=> s_o[DW-1]);
endmodule

// File: rtl/eso_current_observer.sv
module eso_current_observer
    import eso_pkg::*;
#(
    parameter int DW   = 24,
    parameter int CW   = 24,
    parameter int CF   = 20,
    parameter int L1   = 143757,
    parameter int L2   = 7063,
    parameter int L3   = 116,
    parameter int PH12 = 1048576,
    parameter int PH13 = 524288,
    parameter int PH23 = 1048576,
    parameter int G1   = 278,
    parameter int G2   = 555
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_i,
    input  logic signed [DW-1:0] y_i,
    input  logic signed [DW-1:0] u_i,
    output logic                 valid_o,
    output logic signed [DW-1:0] est_pos_o,
    output logic signed [DW-1:0] est_rate_o,
    output logic signed [DW-1:0] est_dist_o
);
    localparam int STG = ESO_STAGES;
    localparam int LGAIN [NSTATE] = '{L1, L2, L3};
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [STG-1:0]        flags;
        logic                  valid;
        logic signed [DW-1:0]  u1;
        logic signed [DW-1:0]  g1_3, g2_3, g1_4, g2_4, g2_5;
        logic signed [DW-1:0]  cb1_4, cb2_4, cb3_4;
        logic signed [DW-1:0]  cb1_5, cb2_5, cb3_5;
        logic signed [DW-1:0]  x1, x2, x3;
        logic signed [DW-1:0]  o1, o2, o3;
    } obs_state_t;

    obs_state_t st_d, st_q;
    logic       accept;

    function automatic logic signed [DW-1:0] sat_sum(input logic signed [DW-1:0] a,
                                                     input logic signed [DW-1:0] b);
        logic [DW:0] s;
        s = {a[DW-1], a} + {b[DW-1], b};
        if (s[DW] != s[DW-1]) return s[DW] ? MINV : MAXV;
        return s[DW-1:0];
    endfunction

    // ---------------- stage 1: estimation error ----------------
    logic signed [DW-1:0] err_w;
    eso_sadd #(.DW(DW), .SUB(1)) u_err (
        .clk(clk), .rst_n(rst_n), .a_i(y_i), .b_i(st_q.x1), .s_o(err_w));

    // ---------------- stage 2: correction and input products ----------------
    logic signed [DW-1:0] corr_w [NSTATE];
    logic signed [DW-1:0] pred_w [NSTATE];
    logic signed [DW-1:0] cb_w   [NSTATE];
    logic signed [DW-1:0] g1_w, g2_w;

    always_comb begin
        pred_w[0] = st_q.x1;
        pred_w[1] = st_q.x2;
        pred_w[2] = st_q.x3;
    end

    for (genvar i = 0; i < NSTATE; i++) begin : g_corr
        eso_cmul #(.DW(DW), .CW(CW), .CF(CF), .COEF(LGAIN[i])) u_gain (
            .clk(clk), .rst_n(rst_n), .a_i(err_w), .p_o(corr_w[i]));
        // stage 3: corrected vector
        eso_sadd #(.DW(DW), .SUB(0)) u_fix (
            .clk(clk), .rst_n(rst_n), .a_i(pred_w[i]), .b_i(corr_w[i]), .s_o(cb_w[i]));
    end

    eso_cmul #(.DW(DW), .CW(CW), .CF(CF), .COEF(G1)) u_in1 (
        .clk(clk), .rst_n(rst_n), .a_i(st_q.u1), .p_o(g1_w));
    eso_cmul #(.DW(DW), .CW(CW), .CF(CF), .COEF(G2)) u_in2 (
        .clk(clk), .rst_n(rst_n), .a_i(st_q.u1), .p_o(g2_w));

    // ---------------- stage 4: transition products ----------------
    logic signed [DW-1:0] m12_w, m13_w, m23_w;
    eso_cmul #(.DW(DW), .CW(CW), .CF(CF), .COEF(PH12)) u_ph12 (
        .clk(clk), .rst_n(rst_n), .a_i(cb_w[1]), .p_o(m12_w));
    eso_cmul #(.DW(DW), .CW(CW), .CF(CF), .COEF(PH13)) u_ph13 (
        .clk(clk), .rst_n(rst_n), .a_i(cb_w[2]), .p_o(m13_w));
    eso_cmul #(.DW(DW), .CW(CW), .CF(CF), .COEF(PH23)) u_ph23 (
        .clk(clk), .rst_n(rst_n), .a_i(cb_w[2]), .p_o(m23_w));

    // ---------------- stage 5: partial sums ----------------
    logic signed [DW-1:0] a1_w, b1_w, a2_w;
    eso_sadd #(.DW(DW), .SUB(0)) u_sum1a (
        .clk(clk), .rst_n(rst_n), .a_i(st_q.cb1_4), .b_i(m12_w), .s_o(a1_w));
    eso_sadd #(.DW(DW), .SUB(0)) u_sum1b (
        .clk(clk), .rst_n(rst_n), .a_i(m13_w), .b_i(st_q.g1_4), .s_o(b1_w));
    eso_sadd #(.DW(DW), .SUB(0)) u_sum2a (
        .clk(clk), .rst_n(rst_n), .a_i(st_q.cb2_4), .b_i(m23_w), .s_o(a2_w));

    // ---------------- next-value logic ----------------
    always_comb begin
        st_d       = st_q;
        accept     = sample_i && (st_q.flags == '0);
        st_d.flags = {st_q.flags[STG-2:0], accept};
        st_d.valid = st_q.flags[STG-1];
        if (accept) st_d.u1 = u_i;
        st_d.g1_3  = g1_w;
        st_d.g2_3  = g2_w;
        st_d.g1_4  = st_q.g1_3;
        st_d.g2_4  = st_q.g2_3;
        st_d.g2_5  = st_q.g2_4;
        st_d.cb1_4 = cb_w[0];
        st_d.cb2_4 = cb_w[1];
        st_d.cb3_4 = cb_w[2];
        st_d.cb1_5 = st_q.cb1_4;
        st_d.cb2_5 = st_q.cb2_4;
        st_d.cb3_5 = st_q.cb3_4;
        if (st_q.flags[STG-1]) begin
            st_d.x1 = sat_sum(a1_w, b1_w);
            st_d.x2 = sat_sum(a2_w, st_q.g2_5);
            st_d.x3 = st_q.cb3_5;
            st_d.o1 = st_q.cb1_5;
            st_d.o2 = st_q.cb2_5;
            st_d.o3 = st_q.cb3_5;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o    = st_q.valid;
    assign est_pos_o  = st_q.o1;
    assign est_rate_o = st_q.o2;
    assign est_dist_o = st_q.o3;

    // R5: an accepted strobe yields a result pulse six cycles later
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##6 valid_o);
    // R5: the result pulse lasts a single cycle
    p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R6: outputs hold outside the result cycle
    p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(est_pos_o) && $stable(est_rate_o) && $stable(est_dist_o)));
    // R6: prediction registers change only at the end of an update
    p_hold_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.flags[STG-1] |=> ($stable(st_q.x1) && $stable(st_q.x2) && $stable(st_q.x3)));
    // R7: at most one update is in flight
    p_one_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.flags));
endmodule

// File: tb/eso_current_observer_bench.sv
module eso_current_observer_bench;
    localparam int CLK_PERIOD_NS = 10;
    localparam int DW = 24;
    localparam int CF = 20;
    localparam longint VMAX = (longint'(1) <<< (DW - 1)) - 1;
    localparam longint VMIN = -(longint'(1) <<< (DW - 1));
    // coefficient order: L1 L2 L3 PH12 PH13 PH23 G1 G2
    localparam longint KA [8] = '{143757, 7063, 116, 1048576, 524288, 1048576, 278, 555};
    localparam longint KB [8] = '{1048576, 3145728, 2097152, 3145728, 3145728, 3145728,
                                  7340032, 7340032};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_i = 1'b0;
    logic signed [DW-1:0] y_i = '0, u_i = '0;
    logic va, vb;
    logic signed [DW-1:0] pa, ra, da, pb, rb, db;

    always #(CLK_PERIOD_NS / 2) clk = ~clk;

    eso_current_observer #(.DW(DW), .CF(CF)) u_eso_current_observer (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .y_i(y_i), .u_i(u_i),
        .valid_o(va), .est_pos_o(pa), .est_rate_o(ra), .est_dist_o(da));

    eso_current_observer #(.DW(DW), .CF(CF),
        .L1(int'(KB[0])), .L2(int'(KB[1])), .L3(int'(KB[2])),
        .PH12(int'(KB[3])), .PH13(int'(KB[4])), .PH23(int'(KB[5])),
        .G1(int'(KB[6])), .G2(int'(KB[7]))) u_eso_current_observer_hi (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .y_i(y_i), .u_i(u_i),
        .valid_o(vb), .est_pos_o(pb), .est_rate_o(rb), .est_dist_o(db));

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    longint st [2][3];
    longint xb [2][3];
    logic [31:0] rs = 32'h1badf00d;

    function automatic longint sat(input longint v);
        if (v > VMAX) return VMAX;
        if (v < VMIN) return VMIN;
        return v;
    endfunction

    function automatic longint mulq(input longint a, input longint c);
        return sat((a * c) >>> CF);
    endfunction

    function automatic longint addq(input longint a, input longint b);
        return sat(a + b);
    endfunction

    function automatic longint kof(input int inst, input int idx);
        return (inst == 0) ? KA[idx] : KB[idx];
    endfunction

    // R2, R3, R4 arithmetic model
    task automatic model_step(input longint y, input longint u);
        for (int k = 0; k < 2; k++) begin
            longint e;
            e = sat(y - st[k][0]);
            for (int i = 0; i < 3; i++) xb[k][i] = addq(st[k][i], mulq(e, kof(k, i)));
            st[k][0] = addq(addq(xb[k][0], mulq(xb[k][1], kof(k, 3))),
                            addq(mulq(xb[k][2], kof(k, 4)), mulq(u, kof(k, 6))));
            st[k][1] = addq(addq(xb[k][1], mulq(xb[k][2], kof(k, 5))), mulq(u, kof(k, 7)));
            st[k][2] = xb[k][2];
        end
    endtask

    task automatic check(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check({tag, " inst0 pos"},  longint'(pa), xb[0][0]);
        check({tag, " inst0 rate"}, longint'(ra), xb[0][1]);
        check({tag, " inst0 dist"}, longint'(da), xb[0][2]);
        check({tag, " inst1 pos"},  longint'(pb), xb[1][0]);
        check({tag, " inst1 rate"}, longint'(rb), xb[1][1]);
        check({tag, " inst1 dist"}, longint'(db), xb[1][2]);
    endtask

    // drive one strobe; inputs are scrambled after the accepting edge (R8)
    task automatic do_sample(input longint y, input longint u, output int lat);
        @(negedge clk);
        y_i = DW'(y); u_i = DW'(u); sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0; y_i = ~y_i; u_i = u_i ^ 24'h5a5a5a;
        lat = 1;
        while (!va && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        model_step(y, u);
    endtask

    function automatic longint rnd(input int bits);
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return (longint'(rs) % (longint'(1) <<< bits)) - (longint'(1) <<< (bits - 1));
    endfunction

    initial begin
        int lat;
        longint hp, hr, hd;
        int neg_hits;
        for (int k = 0; k < 2; k++) for (int i = 0; i < 3; i++) st[k][i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", longint'(va), 0);
        check("R1 pos", longint'(pa), 0);
        check("R1 rate", longint'(ra), 0);
        check("R1 dist", longint'(da), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid after release", longint'(va | vb), 0);

        // R9: positive rail
        do_sample(VMAX, VMAX, lat);
        check("R5 latency", lat, 6);
        compare_all("R9 R4 max inputs");
        check("R9 positive rail pos", longint'(pb), VMAX);
        check("R9 positive rail rate", longint'(rb), VMAX);
        // R9: negative rail
        neg_hits = 0;
        for (int n = 0; n < 4; n++) begin
            do_sample(VMIN, VMIN, lat);
            compare_all("R9 R4 min inputs");
            if (pb == DW'(VMIN) || rb == DW'(VMIN) || db == DW'(VMIN)) neg_hits++;
        end
        check("R9 negative rail reached", longint'(neg_hits > 0), 1);

        // R2, R3, R4, R8: sweep with pseudo-random measurements and inputs
        for (int n = 0; n < 300; n++) begin
            longint yy, uu;
            yy = (n % 50 < 10) ? 1000000 : rnd(22);
            uu = rnd(21);
            do_sample(yy, uu, lat);
            check("R5 latency", lat, 6);
            compare_all("R2/R3/R4/R8 sweep");
        end

        // R6: hold between strobes while inputs move
        hp = longint'(pa); hr = longint'(ra); hd = longint'(da);
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            y_i = DW'(rnd(22)); u_i = DW'(rnd(20));
            if (va || vb) begin
                n_fail++;
                $display("FAIL R6 valid without strobe actual=1 expected=0");
            end
        end
        check("R6 hold pos", longint'(pa), hp);
        check("R6 hold rate", longint'(ra), hr);
        check("R6 hold dist", longint'(da), hd);
        do_sample(-300000, 12345, lat);
        compare_all("R6 state held");

        // R7: strobe while busy is ignored; strobe in the result cycle is accepted
        @(negedge clk);
        y_i = DW'(longint'(777777)); u_i = DW'(longint'(-4444)); sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        @(negedge clk);
        y_i = DW'(longint'(-2000000)); u_i = DW'(longint'(900000)); sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        lat = 3;
        while (!va && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R7 busy strobe latency", lat, 6);
        model_step(777777, -4444);
        compare_all("R7 busy strobe ignored");
        // strobe in the result cycle
        y_i = DW'(longint'(50000)); u_i = DW'(longint'(-70000)); sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        lat = 1;
        while (!va && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R7 strobe in result cycle accepted", lat, 6);
        model_step(50000, -70000);
        compare_all("R7 back-to-back");
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (va) begin
                n_fail++;
                $display("FAIL R7 extra result pulse actual=1 expected=0");
            end
        end

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule